// File: doc/BRIEF.md
# Angle-Scheduled Knock Sampling Window Generator

This block drives one output pin that frames the moments when an analog-to-digital converter should sample a knock sensor. The timing comes from an engine angle counter supplied from outside. A small table holds the sampling windows. Each entry gives a signed start angle and an angular width. Both are measured against a programmable top-dead-centre reference: a positive start lies before that reference and a negative start lies after it. The block folds each start into the angle counter's cycle, so a window may straddle the wrap point. The block then opens each window, in table order, when the angle counter reaches the window's start.

There are two modes. In gate mode the pin stays active for the whole window, so a converter that runs continuously can be gated with it. In trigger mode the pin carries a square wave with 50% duty inside the window, timed in ticks of a separate time base, and each rising half can trigger one conversion. For each of three events (window start, window end and every trigger pulse), an options field enables an interrupt pulse and a DMA pulse independently. A sticky interrupt flag records interrupt pulses until software clears it. The mode, period, options and count can be changed at any time. A change takes effect at the next window start, never partway through an open window.

Top module: `knock_win_gen`

## Requirements
- R1: In gate mode the pin becomes active one cycle after the clock where `angle_now` equals the window's absolute start. It returns to inactive one cycle after the clock where `angle_now` equals the window's absolute end.
- R2: The absolute start is `cfg_tdc` minus the signed (two's complement) table start, folded once into [0, `cycle_len`). The absolute end is the absolute start plus the width, folded the same way. A window whose end lies past the wrap point opens and closes correctly.
- R3: Windows are used in table order, starting from entry 0. After the last entry the block goes back to entry 0, where the last entry is `cfg_count`−1. A count above the table size acts as the table size. A count of zero never opens a window.
- R4: In trigger mode the pin is active from the window start and toggles after every `cfg_period`/2 time-base ticks, only inside the window. If the window ends partway through a half period, the pin goes inactive at once and no trigger event is produced for that pending half.
- R5: `cfg_opts` bits [2:0] enable interrupt pulses for {trigger, end, start}, and bits [5:3] enable DMA pulses for the same three events in the same order. A trigger event occurs at the window start in trigger mode and at every later rising half. Each pulse is one cycle long and appears in the same cycle as the pin change caused by the same event.
- R6: When `cfg_pol`=1 the active level is high. When `cfg_pol`=0 the active level is low. The polarity applies to the pin at once.
- R7: Mode, period, options and count are captured at the window start. Changing them while a window is open has no effect on that window.
- R8: `init_strobe` closes any open window, drives the pin inactive on the next cycle and restarts the table at entry 0.
- R9: `irq_flag` rises together with any `irq_pulse`. It stays high until a cycle with `irq_clr`=1 and no new interrupt event. A new interrupt event wins over a clear in the same cycle.
- R10: After reset the pin is inactive and `irq_pulse`, `dma_pulse` and `irq_flag` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_strobe | input | 1 | Restart the schedule and close any open window |
| angle_now | input | 24 | Engine angle count, wrapping at cycle_len |
| cycle_len | input | 24 | Angle count per engine cycle |
| time_tick | input | 1 | Time-base tick enable for the trigger train |
| cfg_mode | input | 1 | 0 = gate, 1 = trigger |
| cfg_pol | input | 1 | 1 = active high, 0 = active low |
| cfg_tdc | input | 24 | Reference angle that windows are measured against |
| cfg_period | input | 24 | Full trigger period in time-base ticks |
| cfg_opts | input | 6 | Interrupt and DMA event enables |
| cfg_count | input | 4 | Number of table entries in use |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 3 | Table entry index to write |
| tbl_start | input | 24 | Signed start angle relative to the reference |
| tbl_width | input | 24 | Window width in angle counts |
| irq_clr | input | 1 | Write-one clear of the interrupt flag |
| pin | output | 1 | Window/trigger output |
| irq_pulse | output | 1 | One-cycle interrupt request |
| dma_pulse | output | 1 | One-cycle DMA request |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that `angle_now` moves by at most one count per clock and stays below `cycle_len`. They also assume that each window is at least one count wide and shorter than a full cycle, that windows do not overlap, and that a trigger period is at least two ticks. The stimulus meets these conditions. It sweeps the angle one count per clock, places every configured window inside the swept range, and makes table writes and configuration changes only at angles where no window starts. A reference model in the bench predicts every pin edge, interrupt pulse and DMA pulse from the requirements. A scoreboard then matches the design's output against those predictions cycle by cycle.

// File: rtl/knock_pkg.sv
package knock_pkg;

    parameter int ANG_W   = 24;
    parameter int TIME_W  = 24;
    parameter int MAX_WIN = 8;

    localparam int IDX_W = $clog2(MAX_WIN);
    localparam int CNT_W = IDX_W + 1;

    typedef logic [ANG_W-1:0]  angle_t;
    typedef logic [TIME_W-1:0] ticks_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        MODE_GATE = 1'b0,
        MODE_TRIG = 1'b1
    } knock_mode_e;

    // Event enables: one bit each for trigger, end and start
    typedef struct packed {
        logic trig;
        logic fin;
        logic start;
    } evt_en_t;

    // DMA enables in the upper half, interrupt enables in the lower half
    typedef struct packed {
        evt_en_t dma;
        evt_en_t irq;
    } opts_t;

    typedef struct packed {
        angle_t start;
        angle_t width;
    } win_ent_t;

    // Reference angle minus signed relative angle, folded once into [0, len)
    function automatic angle_t fold_sub(angle_t ref_a, angle_t rel, angle_t len);
        logic signed [ANG_W+1:0] d;
        logic signed [ANG_W+1:0] l;
        l = $signed({2'b00, len});
        d = $signed({2'b00, ref_a}) - $signed({{2{rel[ANG_W-1]}}, rel});
        if (d < 0)
            d = d + l;
        else if (d >= l)
            d = d - l;
        return d[ANG_W-1:0];
    endfunction

    // Angle plus width, folded once into [0, len)
    function automatic angle_t fold_add(angle_t a, angle_t w, angle_t len);
        logic [ANG_W:0] s;
        s = {1'b0, a} + {1'b0, w};
        if (s >= {1'b0, len})
            s = s - {1'b0, len};
        return s[ANG_W-1:0];
    endfunction

    function automatic cnt_t clamp_cnt(cnt_t c);
        return (c > CNT_W'(MAX_WIN)) ? CNT_W'(MAX_WIN) : c;
    endfunction

endpackage

// File: rtl/knock_win_table.sv
module knock_win_table
    import knock_pkg::*;
#(
    parameter int DEPTH = MAX_WIN,
    parameter int AW    = IDX_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           we,
    input  logic [AW-1:0]  waddr,
    input  win_ent_t       wdata,
    input  logic [AW-1:0]  raddr,
    output win_ent_t       rdata
);

    win_ent_t ent [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent[g] <= '0;
            else if (we && waddr == AW'(g))
                ent[g] <= wdata;
        end
    end

    assign rdata = ent[raddr];

endmodule

// File: rtl/knock_trig_gen.sv
module knock_trig_gen
    import knock_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  logic   load,
    input  logic   run,
    input  logic   tick,
    input  ticks_t half,
    output logic   phase,
    output logic   rise
);

    ticks_t hcnt;
    logic   wrap_now;

    assign wrap_now = run && tick && (hcnt == half - 1'b1);
    // A rising half begins when the phase flips from low to high
    assign rise     = wrap_now && !phase;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phase <= 1'b0;
            hcnt  <= '0;
        end else if (load) begin
            phase <= 1'b1;
            hcnt  <= '0;
        end else if (!run) begin
            phase <= 1'b0;
            hcnt  <= '0;
        end else if (tick) begin
            if (wrap_now) begin
                hcnt  <= '0;
                phase <= ~phase;
            end else begin
                hcnt <= hcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/knock_seq.sv
module knock_seq
    import knock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  angle_t      angle_now,
    input  angle_t      abs_start,
    input  angle_t      abs_end,
    input  knock_mode_e cfg_mode,
    input  ticks_t      cfg_period,
    input  opts_t       cfg_opts,
    input  cnt_t        cfg_count,
    input  logic        trig_rise,
    output idx_t        win_idx,
    output logic        win_open,
    output knock_mode_e act_mode,
    output ticks_t      half_q,
    output logic        hit_start,
    output logic        hit_end,
    output logic        irq_ev,
    output logic        dma_ev,
    output logic        irq_pulse,
    output logic        dma_pulse
);

    cnt_t   cnt_eff;
    cnt_t   cnt_q;
    angle_t fin_q;
    opts_t  opts_q;
    opts_t  opts_use;
    evt_en_t evs;
    cnt_t   idx_nxt;

    assign cnt_eff   = clamp_cnt(cfg_count);
    assign hit_start = !init && !win_open && (cnt_eff != '0) && (angle_now == abs_start);
    assign hit_end   = !init && win_open && (angle_now == fin_q);

    always_comb begin
        evs.start = hit_start;
        evs.fin   = hit_end;
        evs.trig  = (hit_start && cfg_mode == MODE_TRIG) || trig_rise;
    end

    // The start event uses the options captured with it
    assign opts_use = hit_start ? cfg_opts : opts_q;
    assign irq_ev   = !init && |(opts_use.irq & evs);
    assign dma_ev   = !init && |(opts_use.dma & evs);
    assign idx_nxt  = {1'b0, win_idx} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            win_open <= 1'b0;
            win_idx  <= '0;
        end else if (hit_start) begin
            win_open <= 1'b1;
        end else if (hit_end) begin
            win_open <= 1'b0;
            win_idx  <= (idx_nxt >= cnt_q) ? '0 : idx_nxt[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_mode <= MODE_GATE;
            half_q   <= '0;
            opts_q   <= '0;
            cnt_q    <= '0;
            fin_q    <= '0;
        end else if (hit_start) begin
            act_mode <= cfg_mode;
            half_q   <= cfg_period >> 1;
            opts_q   <= cfg_opts;
            cnt_q    <= cnt_eff;
            fin_q    <= abs_end;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            dma_pulse <= 1'b0;
        end else begin
            irq_pulse <= irq_ev;
            dma_pulse <= dma_ev;
        end
    end

endmodule

// File: rtl/knock_win_gen.sv
module knock_win_gen
    import knock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 init_strobe,
    input  logic [ANG_W-1:0]     angle_now,
    input  logic [ANG_W-1:0]     cycle_len,
    input  logic                 time_tick,
    input  logic                 cfg_mode,
    input  logic                 cfg_pol,
    input  logic [ANG_W-1:0]     cfg_tdc,
    input  logic [TIME_W-1:0]    cfg_period,
    input  logic [5:0]           cfg_opts,
    input  logic [CNT_W-1:0]     cfg_count,
    input  logic                 tbl_we,
    input  logic [IDX_W-1:0]     tbl_addr,
    input  logic [ANG_W-1:0]     tbl_start,
    input  logic [ANG_W-1:0]     tbl_width,
    input  logic                 irq_clr,
    output logic                 pin,
    output logic                 irq_pulse,
    output logic                 dma_pulse,
    output logic                 irq_flag
);

    win_ent_t    wr_ent;
    win_ent_t    cur_ent;
    idx_t        win_idx;
    logic        win_open;
    knock_mode_e act_mode;
    ticks_t      half_q;
    logic        hit_start;
    logic        hit_end;
    logic        irq_ev;
    logic        dma_ev;
    logic        trig_rise;
    logic        trig_phase;
    logic        trig_run;
    logic        trig_load;
    logic        active;
    angle_t      abs_start;
    angle_t      abs_end;

    assign wr_ent.start = tbl_start;
    assign wr_ent.width = tbl_width;

    knock_win_table #(
        .DEPTH (MAX_WIN),
        .AW    (IDX_W)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .we    (tbl_we),
        .waddr (tbl_addr),
        .wdata (wr_ent),
        .raddr (win_idx),
        .rdata (cur_ent)
    );

    assign abs_start = fold_sub(cfg_tdc, cur_ent.start, cycle_len);
    assign abs_end   = fold_add(abs_start, cur_ent.width, cycle_len);

    knock_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .init       (init_strobe),
        .angle_now  (angle_now),
        .abs_start  (abs_start),
        .abs_end    (abs_end),
        .cfg_mode   (knock_mode_e'(cfg_mode)),
        .cfg_period (cfg_period),
        .cfg_opts   (opts_t'(cfg_opts)),
        .cfg_count  (cfg_count),
        .trig_rise  (trig_rise),
        .win_idx    (win_idx),
        .win_open   (win_open),
        .act_mode   (act_mode),
        .half_q     (half_q),
        .hit_start  (hit_start),
        .hit_end    (hit_end),
        .irq_ev     (irq_ev),
        .dma_ev     (dma_ev),
        .irq_pulse  (irq_pulse),
        .dma_pulse  (dma_pulse)
    );

    assign trig_load = hit_start && (knock_mode_e'(cfg_mode) == MODE_TRIG);
    assign trig_run  = win_open && (act_mode == MODE_TRIG) && !hit_end;

    knock_trig_gen u_trig (
        .clk   (clk),
        .rst   (rst),
        .clr   (init_strobe),
        .load  (trig_load),
        .run   (trig_run),
        .tick  (time_tick),
        .half  (half_q),
        .phase (trig_phase),
        .rise  (trig_rise)
    );

    assign active = win_open && ((act_mode == MODE_GATE) || trig_phase);
    assign pin    = cfg_pol ? active : ~active;

    always_ff @(posedge clk) begin
        if (rst)
            irq_flag <= 1'b0;
        else if (irq_ev)
            irq_flag <= 1'b1;
        else if (irq_clr)
            irq_flag <= 1'b0;
    end

endmodule

// File: rtl/knock_win_chk.sv
module knock_win_chk (
    input logic       clk,
    input logic       rst,
    input logic       init_strobe,
    input logic       cfg_pol,
    input logic       pin,
    input logic       irq_pulse,
    input logic       dma_pulse,
    input logic       irq_flag,
    input logic       irq_clr,
    input logic       win_open,
    input logic       mode_trig,
    input logic [2:0] win_idx
);

    // R8
    init_clears_chk: assert property (@(posedge clk) disable iff (rst)
        init_strobe |=> (!win_open && pin == !cfg_pol && win_idx == 3'd0));

    // R9
    flag_follows_irq_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_flag);

    // R9
    flag_clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_flag) |-> $past(irq_clr));

    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !win_open |-> (pin == !cfg_pol));

    // R1
    gate_level_chk: assert property (@(posedge clk) disable iff (rst)
        (win_open && !mode_trig) |-> (pin == cfg_pol));

    // R5
    dma_origin_chk: assert property (@(posedge clk) disable iff (rst)
        dma_pulse |-> (win_open || $past(win_open)));

endmodule

bind knock_win_gen knock_win_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .init_strobe (init_strobe),
    .cfg_pol     (cfg_pol),
    .pin         (pin),
    .irq_pulse   (irq_pulse),
    .dma_pulse   (dma_pulse),
    .irq_flag    (irq_flag),
    .irq_clr     (irq_clr),
    .win_open    (win_open),
    .mode_trig   (act_mode),
    .win_idx     (win_idx)
);

// File: tb/knock_win_gen_bench.sv
module knock_win_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LEN        = 100;
    localparam int K_PIN      = 0;
    localparam int K_IRQ      = 1;
    localparam int K_DMA      = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_strobe = 1'b0;
    logic [23:0] angle_now = '0;
    logic [23:0] cycle_len = 24'(LEN);
    logic        time_tick = 1'b0;
    logic        cfg_mode = 1'b0;
    logic        cfg_pol = 1'b1;
    logic [23:0] cfg_tdc = 24'd50;
    logic [23:0] cfg_period = 24'd4;
    logic [5:0]  cfg_opts = 6'b111111;
    logic [3:0]  cfg_count = 4'd2;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_addr = '0;
    logic [23:0] tbl_start = '0;
    logic [23:0] tbl_width = '0;
    logic        irq_clr = 1'b0;
    logic        pin;
    logic        irq_pulse;
    logic        dma_pulse;
    logic        irq_flag;

    knock_win_gen u_knock_win_gen (
        .clk         (clk),
        .rst         (rst),
        .init_strobe (init_strobe),
        .angle_now   (angle_now),
        .cycle_len   (cycle_len),
        .time_tick   (time_tick),
        .cfg_mode    (cfg_mode),
        .cfg_pol     (cfg_pol),
        .cfg_tdc     (cfg_tdc),
        .cfg_period  (cfg_period),
        .cfg_opts    (cfg_opts),
        .cfg_count   (cfg_count),
        .tbl_we      (tbl_we),
        .tbl_addr    (tbl_addr),
        .tbl_start   (tbl_start),
        .tbl_width   (tbl_width),
        .irq_clr     (irq_clr),
        .pin         (pin),
        .irq_pulse   (irq_pulse),
        .dma_pulse   (dma_pulse),
        .irq_flag    (irq_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int    cyc;
        int    kind;
        bit    val;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R10";

    // Next-cycle configuration, applied at the negedge inside step
    bit        n_mode = 0, n_pol = 1, n_clr = 0;
    int        n_tdc = 50, n_period = 4, n_opts = 6'b111111, n_count = 2;

    // Reference model state
    int m_open = 0, m_idx = 0, m_phase = 0, m_hcnt = 0, m_mode = 0;
    int m_half = 0, m_opts = 0, m_cnt = 0, m_fin = 0;
    bit m_pin_prev = 1'b0;
    int m_st [8];
    int m_wd [8];
    int cur = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic bit model_pin();
        bit act;
        act = (m_open != 0) && (m_mode == 0 || m_phase != 0);
        return cfg_pol ? act : !act;
    endfunction

    task automatic push(input int kind, input bit val);
        exp_item_t it;
        it.cyc = cyc + 1;
        it.kind = kind;
        it.val = val;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic model(input int a, input bit t, input bit ini);
        int es = 0, ee = 0, et = 0, cnt, s, e, op;
        bit irq, dma, np;
        cnt = (cfg_count > 8) ? 8 : int'(cfg_count);
        s = int'(cfg_tdc) - m_st[m_idx];
        if (s < 0) s += LEN; else if (s >= LEN) s -= LEN;
        e = s + m_wd[m_idx];
        if (e >= LEN) e -= LEN;
        op = m_opts;
        if (ini) begin
            m_open = 0; m_idx = 0; m_phase = 0; m_hcnt = 0;
        end else if (m_open == 0) begin
            if (cnt != 0 && a == s) begin
                m_open = 1; m_mode = int'(cfg_mode); m_half = int'(cfg_period) / 2;
                m_opts = int'(cfg_opts); op = m_opts; m_cnt = cnt; m_fin = e;
                m_phase = m_mode; m_hcnt = 0; es = 1; et = m_mode;
            end
        end else if (a == m_fin) begin
            m_open = 0; m_phase = 0; m_hcnt = 0; ee = 1;
            m_idx = (m_idx + 1 >= m_cnt) ? 0 : m_idx + 1;
        end else if (m_mode != 0 && t) begin
            if (m_hcnt == m_half - 1) begin
                m_hcnt = 0; m_phase = (m_phase != 0) ? 0 : 1; et = m_phase;
            end else begin
                m_hcnt++;
            end
        end
        irq = (op[0] && es != 0) || (op[1] && ee != 0) || (op[2] && et != 0);
        dma = (op[3] && es != 0) || (op[4] && ee != 0) || (op[5] && et != 0);
        np = model_pin();
        if (np != m_pin_prev) push(K_PIN, np);
        m_pin_prev = np;
        if (irq) push(K_IRQ, 1'b1);
        if (dma) push(K_DMA, 1'b1);
    endtask

    // One clock of stimulus: drive at the negedge and predict the outcome
    task automatic step(input int a, input bit t, input bit ini, input bit we);
        @(negedge clk);
        angle_now   = 24'(a);
        time_tick   = t;
        init_strobe = ini;
        tbl_we      = we;
        cfg_mode    = n_mode;
        cfg_pol     = n_pol;
        cfg_tdc     = 24'(n_tdc);
        cfg_period  = 24'(n_period);
        cfg_opts    = 6'(n_opts);
        cfg_count   = 4'(n_count);
        irq_clr     = n_clr;
        cur = a;
        model(a, t, ini);
    endtask

    task automatic wr(input int k, input int st, input int wd);
        tbl_addr  = 3'(k);
        tbl_start = 24'(st);
        tbl_width = 24'(wd);
        step(cur, 1'b0, 1'b0, 1'b1);
        m_st[k] = st;
        m_wd[k] = wd;
        step(cur, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic sweep(input int a0, input int n, input int div);
        for (int i = 0; i < n; i++)
            step((a0 + i) % LEN, (i % div) == 0, 1'b0, 1'b0);
    endtask

    // Scoreboard monitor: samples just after each rising edge
    bit ppin;
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            while (sb_q.size() > 0 && sb_q[0].cyc < cyc) begin
                check(1'b0, {sb_q[0].tag, " missing event"}, sb_q[0].kind, sb_q[0].cyc);
                void'(sb_q.pop_front());
            end
            if (pin != ppin) mon_item(K_PIN, pin);
            if (irq_pulse) mon_item(K_IRQ, 1'b1);
            if (dma_pulse) mon_item(K_DMA, 1'b1);
            ppin = pin;
        end
    end

    task automatic mon_item(input int kind, input bit val);
        bit ok;
        string t;
        ok = sb_q.size() > 0 && sb_q[0].cyc == cyc && sb_q[0].kind == kind && sb_q[0].val == val;
        t = (sb_q.size() > 0) ? sb_q[0].tag : "unexpected";
        check(ok, {t, " event kind/cycle"}, kind * 10 + int'(val), cyc);
        if (ok) void'(sb_q.pop_front());
    endtask

    initial begin
        for (int k = 0; k < 8; k++) begin
            m_st[k] = 0;
            m_wd[k] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(pin == 1'b1 ? 1'b0 : 1'b1, "R10 pin inactive", int'(pin), 0);
        check(!irq_pulse && !dma_pulse, "R10 pulses low", int'(irq_pulse) + int'(dma_pulse), 0);
        check(!irq_flag, "R10 flag low", int'(irq_flag), 0);
        for (int k = 0; k < 8; k++) m_wd[k] = 0;
        ppin = pin;
        m_pin_prev = pin;
        mon_on = 1'b1;
        cur = 30;

        // R1 R2 R3: gate windows 40..45 and 70..78, two revolutions
        tag = "R1 R3";
        wr(0, 10, 5);
        wr(1, -20, 8);
        sweep(0, 200, 1);

        // R2: window folded across the wrap point, 95..5
        tag = "R2";
        n_count = 1;
        step(30, 0, 1, 0);
        wr(0, -45, 10);
        sweep(0, 200, 1);

        // R4: trigger train, end partway through a high half
        tag = "R4";
        n_mode = 1; n_period = 4;
        step(30, 0, 1, 0);
        wr(0, 10, 9);
        sweep(0, 100, 1);
        n_period = 6;
        sweep(0, 100, 2);

        // R5: separate interrupt and DMA selections
        tag = "R5";
        n_opts = 6'b010001;
        sweep(0, 100, 1);
        n_mode = 0; n_opts = 6'b001110;
        sweep(0, 100, 1);

        // R6: active-low output
        tag = "R6";
        n_pol = 0; n_opts = 6'b111111;
        sweep(0, 100, 1);
        n_pol = 1;
        step(30, 0, 0, 0);

        // R7: configuration changes inside an open window
        tag = "R7";
        n_count = 2;
        step(30, 0, 1, 0);
        wr(0, 10, 11);
        wr(1, -20, 8);
        sweep(0, 44, 1);
        n_mode = 1; n_opts = 0; n_period = 2;
        sweep(44, 56, 1);
        n_mode = 0; n_opts = 6'b111111;
        sweep(0, 100, 1);

        // R8: restart in the middle of a window
        tag = "R8";
        step(30, 0, 1, 0);
        sweep(0, 43, 1);
        step(43, 0, 1, 0);
        sweep(44, 156, 1);

        // R3: all eight entries, count above table size, then count zero
        tag = "R3";
        step(30, 0, 1, 0);
        for (int k = 0; k < 8; k++) wr(k, 48 - 10 * k, 3);
        n_count = 9;
        sweep(0, 200, 1);
        n_count = 0;
        step(30, 0, 1, 0);
        sweep(0, 100, 1);

        // R9: sticky flag, clear, and set winning over clear
        tag = "R9";
        n_count = 1; n_opts = 6'b000001;
        step(30, 0, 1, 0);
        sweep(0, 3, 1);
        check(irq_flag, "R9 flag set", int'(irq_flag), 1);
        sweep(3, 20, 1);
        check(irq_flag, "R9 flag sticky", int'(irq_flag), 1);
        n_clr = 1;
        step(23, 0, 0, 0);
        n_clr = 0;
        step(24, 0, 0, 0);
        check(!irq_flag, "R9 flag cleared", int'(irq_flag), 0);
        sweep(25, 77, 1);
        n_clr = 1;
        step(2, 0, 0, 0);
        n_clr = 0;
        step(3, 0, 0, 0);
        check(irq_flag, "R9 set wins over clear", int'(irq_flag), 1);
        sweep(4, 20, 1);

        repeat (4) step(30, 0, 0, 0);
        check(sb_q.size() == 0, "R1 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog expired: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule